// File: doc/BRIEF.md
# Exception Status and Cause Unit

This block sits beside a processor pipeline and holds the three control registers the trap path needs: a status word, a cause word and an exception return address. Each cycle it decides whether an exception is taken. A synchronous fault strobe from the pipeline always causes one. An external interrupt causes one when interrupts are enabled and a pending level is unmasked. The decision is reported in the same cycle, together with a fixed handler entry address.

When an exception is taken, the unit saves the interrupt-enable and kernel/user state by pushing a three-entry stack held in the low status bits. It then enters kernel mode with interrupts disabled, records a 4-bit reason code and captures the instruction address. A return strobe pops the stack. Software reads all three registers through one read port. It can write only the status word, and only while the current mode is kernel.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After a synchronous active-low reset, the status, cause and return-address registers are all zero, `kernel_mode_o` is 1 and `take_exc_o` is 0 while no fault is strobed.
- R2: A cycle with `sync_exc_i` high asserts `take_exc_o` in that same cycle. After the clock edge, cause bits 5:2 hold the strobed code and `epc_o` holds `inst_pc_i` from that cycle.
- R3: Status bit 0 is the current interrupt enable (1 = enabled) and bit 1 is the current mode (0 = kernel, 1 = user). Bits 3:2 hold the previous pair and bits 5:4 the oldest pair. Taking an exception moves bits 3:0 into bits 5:2 and clears bits 1:0.
- R4: A return strobe without a taken exception copies status bits 5:2 into bits 3:0 and leaves bits 5:4 unchanged.
- R5: Cause bits 15:11 show the five interrupt lines as sampled at the previous clock edge, one bit per line.
- R6: An interrupt is taken only when status bit 0 is 1 and some cause bit in 15:11 is 1 together with the status mask bit at the same position in 15:11. Its code is 0.
- R7: When a fault strobe and a qualifying interrupt occur in the same cycle, the recorded code is the fault code.
- R8: A status write (select 0) takes effect only while status bit 1 is 0. It stores bits 15:11 and 5:0 of the write data and clears all other bits.
- R9: Writes with select 1 (cause) or select 2 (return address) change no register.
- R10: In a cycle that takes an exception, a return strobe and a status write have no effect. Only the exception update of R3 happens.
- R11: `handler_pc_o` is always 0x80000080. `csr_rdata_o` returns status for select 0, cause for 1, return address for 2 and zero for 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_exc_i | input | 1 | Synchronous fault strobe from the pipeline |
| sync_code_i | input | 4 | Reason code of the fault |
| irq_lines_i | input | 5 | Level-held hardware interrupt requests |
| inst_pc_i | input | 32 | Address of the faulting or interrupted instruction |
| rfe_i | input | 1 | Return-from-exception strobe |
| csr_wr_i | input | 1 | Software register write strobe |
| csr_sel_i | input | 2 | Register select: 0 status, 1 cause, 2 return address |
| csr_wdata_i | input | 32 | Software write data |
| csr_rdata_o | output | 32 | Selected register contents |
| take_exc_o | output | 1 | An exception is taken this cycle |
| handler_pc_o | output | 32 | Handler entry address |
| kernel_mode_o | output | 1 | 1 while the current mode is kernel |
| status_o | output | 32 | Status register |
| cause_o | output | 32 | Cause register |
| epc_o | output | 32 | Return-address register |

## Verification
The hardest situation to reach is an interrupt taken through one particular mask bit. It needs a kernel write that sets the mask and enables interrupts, a line held for one cycle so the pending bit is latched, and a second cycle for the decision. After that, a return must restore the enable state before the next trial. The bench walks every pair of mask pattern and line pattern through that four-step sequence. It then runs a long mixed sequence of faults, returns, writes and line changes in both modes against an arithmetic model, so that the stack is driven two and three levels deep.

// File: rtl/exc_pkg.sv
// Shared field positions and selectors for the exception status and cause unit.
// Assumes a five-level interrupt field at bits 15:11 and a 4-bit code at bits 5:2.
package exc_pkg;
    localparam int IE_CUR    = 0;
    localparam int KU_CUR    = 1;
    localparam int STACK_W   = 6;
    localparam int LVL_LSB   = 11;
    localparam int NUM_LVL   = 5;
    localparam int CODE_LSB  = 2;
    localparam int CODE_W    = 4;
    localparam logic [CODE_W-1:0] CODE_IRQ = '0;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_EPC    = 2'd2,
        SEL_NONE   = 2'd3
    } csr_sel_e;
endpackage

// File: rtl/exc_irq_gate.sv
// Samples the interrupt lines into pending flops, one per level, and raises a
// request when interrupts are enabled and a pending level is unmasked.
// Assumes devices hold their line until software services them.
module exc_irq_gate #(
    parameter int NUM_LVL = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] lines_i,
    input  logic [NUM_LVL-1:0] mask_i,
    input  logic               ie_i,
    output logic [NUM_LVL-1:0] pend_o,
    output logic               irq_req_o
);
    logic [NUM_LVL-1:0] pend_q;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        // Pending flop for one level: copy of its line at the last edge.
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[g] <= 1'b0;
            else        pend_q[g] <= lines_i[g];
        end
    end

    // Request only when enabled and at least one pending level is unmasked.
    always_comb irq_req_o = ie_i & (|(pend_q & mask_i));

    assign pend_o = pend_q;

    p_pend_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pend_o == $past(lines_i));
endmodule

// File: rtl/exc_mode_stack.sv
// Status register: three-pair enable/mode stack in bits 5:0 and the level mask
// in bits 15:11. Exception entry pushes, return pops, kernel writes load.
// Assumes take has priority over return, and return over write.
module exc_mode_stack #(
    parameter int W       = 32,
    parameter int NUM_LVL = 5,
    parameter int LVL_LSB = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take_i,
    input  logic         rfe_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] status_o
);
    import exc_pkg::*;

    localparam logic [W-1:0] LVL_ONES  = {{(W-NUM_LVL){1'b0}}, {NUM_LVL{1'b1}}};
    localparam logic [W-1:0] STACK_ONES = {{(W-STACK_W){1'b0}}, {STACK_W{1'b1}}};
    localparam logic [W-1:0] WR_MASK   = (LVL_ONES << LVL_LSB) | STACK_ONES;

    logic [W-1:0] st_q;
    logic [W-1:0] st_d;
    logic         in_user;

    assign in_user = st_q[KU_CUR];

    // Next status: push on entry, pop on return, load on a kernel write.
    always_comb begin
        st_d = st_q;
        if (take_i) begin
            st_d[STACK_W-1:2] = st_q[STACK_W-3:0];
            st_d[1:0]         = 2'b00;
        end else if (rfe_i) begin
            st_d[STACK_W-3:0] = st_q[STACK_W-1:2];
        end else if (wr_i && !in_user) begin
            st_d = wdata_i & WR_MASK;
        end
    end

    // Status register update.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q;

    p_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (status_o[5:2] == $past(status_o[3:0])) && (status_o[1:0] == 2'b00));
    p_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe_i && !take_i) |=> (status_o[3:0] == $past(status_o[5:2]))
                             && (status_o[5:4] == $past(status_o[5:4])));
    p_user_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && status_o[KU_CUR] && !take_i && !rfe_i) |=> $stable(status_o));
    p_take_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> status_o[W-1:STACK_W] == $past(status_o[W-1:STACK_W]));
endmodule

// File: rtl/exc_capture.sv
// Records the reason code and instruction address when an exception is taken.
// A fault strobe outranks an interrupt taken in the same cycle.
module exc_capture #(
    parameter int ADDR_W = 32,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              sync_i,
    input  logic [CODE_W-1:0] sync_code_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic [CODE_W-1:0] code_o,
    output logic [ADDR_W-1:0] epc_o
);
    import exc_pkg::*;

    logic [CODE_W-1:0] code_q;
    logic [ADDR_W-1:0] epc_q;
    logic [CODE_W-1:0] code_sel;

    // Reason selection: the fault code first, the interrupt code otherwise.
    always_comb code_sel = sync_i ? sync_code_i : CODE_W'(CODE_IRQ);

    // Capture registers, loaded only on a taken exception.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            epc_q  <= '0;
        end else if (take_i) begin
            code_q <= code_sel;
            epc_q  <= pc_i;
        end
    end

    assign code_o = code_q;
    assign epc_o  = epc_q;

    p_epc_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> epc_o == $past(pc_i));
    p_fault_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> code_o == $past(sync_code_i));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(code_o) && $stable(epc_o));
endmodule

// File: rtl/exc_ctrl_unit.sv
// Exception status and cause unit: decides exception entry, keeps the
// enable/mode stack, pending levels, reason code and return address, and
// serves software reads and kernel-only status writes.
// Assumes one fault strobe per cycle and level-held interrupt lines.
module exc_ctrl_unit #(
    parameter int          ADDR_W  = 32,
    parameter logic [31:0] VECTOR  = 32'h8000_0080
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sync_exc_i,
    input  logic [exc_pkg::CODE_W-1:0]  sync_code_i,
    input  logic [exc_pkg::NUM_LVL-1:0] irq_lines_i,
    input  logic [ADDR_W-1:0]           inst_pc_i,
    input  logic                        rfe_i,
    input  logic                        csr_wr_i,
    input  logic [1:0]                  csr_sel_i,
    input  logic [31:0]                 csr_wdata_i,
    output logic [31:0]                 csr_rdata_o,
    output logic                        take_exc_o,
    output logic [ADDR_W-1:0]           handler_pc_o,
    output logic                        kernel_mode_o,
    output logic [31:0]                 status_o,
    output logic [31:0]                 cause_o,
    output logic [ADDR_W-1:0]           epc_o
);
    import exc_pkg::*;

    logic [31:0]         status_w;
    logic [NUM_LVL-1:0]  pend_w;
    logic                irq_req_w;
    logic [CODE_W-1:0]   code_w;
    logic                take_w;
    logic                st_wr_w;

    // Entry decision: any fault, or a qualifying interrupt.
    always_comb take_w = sync_exc_i | irq_req_w;

    // Software write aimed at the status register.
    always_comb st_wr_w = csr_wr_i && (csr_sel_e'(csr_sel_i) == SEL_STATUS);

    exc_irq_gate #(.NUM_LVL(NUM_LVL)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_i  (irq_lines_i),
        .mask_i   (status_w[LVL_LSB +: NUM_LVL]),
        .ie_i     (status_w[IE_CUR]),
        .pend_o   (pend_w),
        .irq_req_o(irq_req_w)
    );

    exc_mode_stack #(.W(32), .NUM_LVL(NUM_LVL), .LVL_LSB(LVL_LSB)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (take_w),
        .rfe_i   (rfe_i),
        .wr_i    (st_wr_w),
        .wdata_i (csr_wdata_i),
        .status_o(status_w)
    );

    exc_capture #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (take_w),
        .sync_i     (sync_exc_i),
        .sync_code_i(sync_code_i),
        .pc_i       (inst_pc_i),
        .code_o     (code_w),
        .epc_o      (epc_o)
    );

    // Cause word assembly: pending levels and the last reason code.
    always_comb begin
        cause_o = '0;
        cause_o[LVL_LSB +: NUM_LVL] = pend_w;
        cause_o[CODE_LSB +: CODE_W] = code_w;
    end

    // Software read mux.
    always_comb begin
        unique case (csr_sel_e'(csr_sel_i))
            SEL_STATUS: csr_rdata_o = status_w;
            SEL_CAUSE:  csr_rdata_o = cause_o;
            SEL_EPC:    csr_rdata_o = 32'(epc_o);
            default:    csr_rdata_o = '0;
        endcase
    end

    assign take_exc_o    = take_w;
    assign handler_pc_o  = ADDR_W'(VECTOR);
    assign kernel_mode_o = ~status_w[KU_CUR];
    assign status_o      = status_w;

    p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_exc_i && !status_o[IE_CUR]) |-> !take_exc_o);
    p_fault_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_exc_i |-> take_exc_o);
    p_entry_kernel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc_o |=> kernel_mode_o && !status_o[IE_CUR]);
endmodule

// File: tb/exc_ctrl_unit_tb_top.sv
`timescale 1ns/1ps
module exc_ctrl_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_exc_i = 1'b0;
    logic [3:0]  sync_code_i = '0;
    logic [4:0]  irq_lines_i = '0;
    logic [31:0] inst_pc_i = '0;
    logic        rfe_i = 1'b0;
    logic        csr_wr_i = 1'b0;
    logic [1:0]  csr_sel_i = '0;
    logic [31:0] csr_wdata_i = '0;
    logic [31:0] csr_rdata_o;
    logic        take_exc_o;
    logic [31:0] handler_pc_o;
    logic        kernel_mode_o;
    logic [31:0] status_o, cause_o, epc_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_status = '0, m_cause = '0, m_epc = '0;
    localparam logic [31:0] WMASK = 32'h0000_F83F;

    always #2.5 clk = ~clk;

    exc_ctrl_unit dut_i (.*);

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic sync, input logic [3:0] code,
                        input logic [4:0] lines, input logic [31:0] pc,
                        input logic rfe, input logic wr, input logic [1:0] sel,
                        input logic [31:0] wdata, input string tag);
        logic exp_take;
        logic [31:0] exp_rd;
        @(negedge clk);
        sync_exc_i = sync; sync_code_i = code; irq_lines_i = lines;
        inst_pc_i = pc; rfe_i = rfe; csr_wr_i = wr; csr_sel_i = sel; csr_wdata_i = wdata;
        #1;
        exp_take = sync | (m_status[0] & (|(m_cause[15:11] & m_status[15:11])));
        chk(tag, "take", {31'd0, take_exc_o}, {31'd0, exp_take});
        chk("R11", "vector", handler_pc_o, 32'h8000_0080);
        exp_rd = (sel == 2'd0) ? m_status : (sel == 2'd1) ? m_cause :
                 (sel == 2'd2) ? m_epc : 32'd0;
        chk("R11", "rdata", csr_rdata_o, exp_rd);
        if (exp_take) begin
            m_status[5:0] = {m_status[3:0], 2'b00};
            m_cause[5:2]  = sync ? code : 4'd0;
            m_epc         = pc;
        end else if (rfe) begin
            m_status[3:0] = m_status[5:2];
        end else if (wr && sel == 2'd0 && !m_status[1]) begin
            m_status = wdata & WMASK;
        end
        m_cause[15:11] = lines;
        @(posedge clk); #1;
        chk(tag, "status", status_o, m_status);
        chk(tag, "cause", cause_o, m_cause);
        chk(tag, "epc", epc_o, m_epc);
        chk(tag, "kernel", {31'd0, kernel_mode_o}, {31'd0, ~m_status[1]});
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "status", status_o, 32'd0);
        chk("R1", "cause", cause_o, 32'd0);
        chk("R1", "epc", epc_o, 32'd0);
        chk("R1", "kernel", {31'd0, kernel_mode_o}, 32'd1);
        chk("R1", "take", {31'd0, take_exc_o}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R8: kernel write, then user write ignored
        step(0, 0, 0, 0, 0, 1, 2'd0, 32'hFFFF_FFFF, "R8");
        step(0, 0, 0, 0, 0, 1, 2'd0, 32'h0000_0000, "R8");
        // R2 R3: fault from user mode pushes the stack
        step(1, 4'd5, 0, 32'h0000_1234, 0, 0, 2'd0, 0, "R2");
        step(1, 4'd9, 0, 32'h0000_2000, 0, 0, 2'd0, 0, "R3");
        // R4: two pops
        step(0, 0, 0, 0, 1, 0, 2'd0, 0, "R4");
        step(0, 0, 0, 0, 1, 0, 2'd0, 0, "R4");
        // R9: cause and epc writes ignored (now in user mode, go to kernel via fault)
        step(1, 4'd3, 0, 32'h40, 0, 0, 2'd0, 0, "R2");
        step(0, 0, 0, 0, 0, 1, 2'd1, 32'hFFFF_FFFF, "R9");
        step(0, 0, 0, 0, 0, 1, 2'd2, 32'hFFFF_FFFF, "R9");
        step(0, 0, 0, 0, 0, 0, 2'd3, 0, "R11");
        // R5 R6: enable, latch a line, take
        step(0, 0, 0, 0, 0, 1, 2'd0, 32'h0000_2001, "R8");
        step(0, 0, 5'b00100, 32'h80, 0, 0, 2'd1, 0, "R5");
        step(0, 0, 5'b00100, 32'h84, 0, 0, 2'd1, 0, "R6");
        step(0, 0, 0, 0, 1, 0, 2'd0, 0, "R4");
        // R6: masked line not taken
        step(0, 0, 5'b00010, 32'h90, 0, 0, 2'd0, 0, "R6");
        step(0, 0, 5'b00010, 32'h94, 0, 0, 2'd0, 0, "R6");
        // R7: fault and interrupt together
        step(0, 0, 5'b00100, 32'hA0, 0, 0, 2'd0, 0, "R7");
        step(1, 4'd12, 5'b00100, 32'hA4, 0, 0, 2'd0, 0, "R7");
        // R10: take with return and write in the same cycle
        step(1, 4'd7, 0, 32'hB0, 1, 1, 2'd0, 32'h0000_0000, "R10");
        step(1, 4'd6, 0, 32'hB4, 1, 1, 2'd0, 32'hFFFF_FFFF, "R10");

        // Sweep every mask against every line pattern (R6 R5)
        for (int m = 0; m < 32; m++) begin
            for (int l = 0; l < 32; l++) begin
                step(0, 0, 0, 0, 1, 0, 2'd0, 0, "R4");
                step(0, 0, 0, 0, 0, 1, 2'd0, 32'(m) << 11 | 32'h1, "R8");
                step(0, 0, 5'(l), 32'(l), 0, 0, 2'd1, 0, "R5");
                step(0, 0, 5'(l), 32'(m), 0, 0, 2'd2, 0, "R6");
            end
        end

        // Mixed sequence driving the stack deep (R3 R4 R8 R10)
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] & r[1] & r[2], r[6:3], r[11:7], $urandom, r[12] & r[13],
                 r[14], r[16:15], $urandom, "R3 R4 R8 R10 mix");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule